// File: doc/BRIEF.md
# Addressed Two-Channel Serial DAC Writer

This block sits on a host CPU bus and drives serial DAC channels, two by default, each on its own set of four lines. Every channel has a fixed bus address. A single-cycle host write to that address captures the data word for that channel and starts a serial transfer on it. Writes to any other address, or cycles without the write strobe, leave every channel alone.

A registered decode stage turns each matching write into a one-cycle start pulse for the channel it names. In that same cycle it latches the word for that channel. One serializer design is instantiated once per channel. It lowers chip select and shifts the word out MSB first on a divided serial clock. It then releases chip select and gives a separate active-low load strobe before it returns to idle. A per-channel busy flag covers the whole sequence. A write that reaches a busy channel is discarded.

Top module: `dacw_top`

## Requirements
- R1: A write (`wr_i` high for one cycle) whose `addr_i` equals channel k's address starts a transfer on channel k only. The default addresses are 0x10 for channel 0 and 0x11 for channel 1.
- R2: When `wr_i` is low, or when `addr_i` matches no channel, no channel starts a frame.
- R3: `busy_o[k]` is still low at the first clock edge after the write is sampled. It goes high at the second edge: one decode register plus one serializer register.
- R4: Each frame carries the captured 16-bit word MSB first. `sdi_o` changes only while the serial clock is low, so it is stable for the whole high phase.
- R5: The serial clock idles low and is never high while chip select is high. Each bit lasts DIV system cycles (default 4): low for DIV/2 cycles, then high for DIV-DIV/2 cycles.
- R6: `cs_no[k]` goes low when the frame starts and stays low for exactly 16 serial-clock rising edges. It goes high again after the last falling edge.
- R7: `ldac_no[k]` goes low one cycle after chip select rises and stays low for DIV cycles. It is never low while chip select is low.
- R8: `busy_o[k]` is high from the start of the frame until the load strobe ends. It falls on the same edge at which `ldac_no[k]` returns high.
- R9: A write to a channel whose busy flag is high is dropped. The running frame keeps its original word and no extra frame follows.
- R10: The channels are independent. A write to one channel while the other is shifting or strobing runs concurrently, and neither frame is disturbed.
- R11: After reset, all chip selects and load strobes are high, and all serial clocks and busy flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Host bus address |
| data_i | input | DW | Host write data |
| wr_i | input | 1 | Single-cycle write strobe |
| cs_no | output | N_CH | Per-channel chip select, active low |
| sck_o | output | N_CH | Per-channel serial clock |
| sdi_o | output | N_CH | Per-channel serial data |
| ldac_no | output | N_CH | Per-channel load strobe, active low |
| busy_o | output | N_CH | Per-channel transfer in progress |

## Verification
A write that the decoder accepts for one channel can land in the same cycle as the other channel's shifting or its load strobe. A write can also reach a channel that is still busy with its own frame. The bench provokes both cases. It issues back-to-back writes to the two channels, times a channel 1 write to the low phase of channel 0's load strobe, and re-writes channel 0 in the middle of its frame. A monitor rebuilds every frame from the serial lines alone. Each case is judged by the recovered words, by the frame counts per channel, and by the timing of the strobe and busy flag.

// File: rtl/dacw_pkg.sv
package dacw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_LOAD  = 2'd2
  } dacw_state_e;
endpackage

// File: rtl/dacw_decode.sv
module dacw_decode #(
  parameter int                    N_CH    = 2,
  parameter int                    ADDR_W  = 8,
  parameter int                    DW      = 16,
  parameter logic [N_CH*ADDR_W-1:0] CH_ADDR = {8'h11, 8'h10}
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DW-1:0]        data_i,
  input  logic                 wr_i,
  output logic [N_CH-1:0]      start_o,
  output logic [N_CH*DW-1:0]   data_o
);
  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    localparam logic [ADDR_W-1:0] MY_ADDR = CH_ADDR[k*ADDR_W +: ADDR_W];
    logic hit;
    assign hit = wr_i && (addr_i == MY_ADDR);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        start_o[k]            <= 1'b0;
        data_o[k*DW +: DW]    <= '0;
      end else begin
        start_o[k] <= hit;  // defaults low every cycle
        if (hit) data_o[k*DW +: DW] <= data_i;
      end
    end

    assert_start_src_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      start_o[k] |-> ($past(wr_i) && $past(addr_i) == MY_ADDR));
  end
endmodule

// File: rtl/dacw_serializer.sv
module dacw_serializer
  import dacw_pkg::*;
#(
  parameter int DW  = 16,
  parameter int DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [DW-1:0] data_i,
  output logic          cs_no,
  output logic          sck_o,
  output logic          sdi_o,
  output logic          ldac_no,
  output logic          busy_o
);
  localparam int LOW_CYC = DIV / 2;
  localparam int CW      = $clog2(DIV + 1);
  localparam int BW      = (DW > 1) ? $clog2(DW) : 1;

  dacw_state_e   state_q;
  logic [CW-1:0] div_q;
  logic [BW-1:0] bit_q;
  logic [DW-1:0] sh_q;
  logic          cs_q, sck_q, ldac_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      div_q   <= '0;
      bit_q   <= '0;
      sh_q    <= '0;
      cs_q    <= 1'b1;
      sck_q   <= 1'b0;
      ldac_q  <= 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            state_q <= ST_SHIFT;
            sh_q    <= data_i;
            cs_q    <= 1'b0;
            sck_q   <= 1'b0;
            div_q   <= '0;
            bit_q   <= '0;
          end
        end
        ST_SHIFT: begin
          if (div_q == CW'(DIV - 1)) begin
            div_q <= '0;
            sck_q <= 1'b0;  // falling edge: advance bit
            if (bit_q == BW'(DW - 1)) begin
              state_q <= ST_LOAD;
              cs_q    <= 1'b1;
            end else begin
              bit_q <= bit_q + 1'b1;
              sh_q  <= {sh_q[DW-2:0], 1'b0};
            end
          end else begin
            div_q <= div_q + 1'b1;
            if (div_q == CW'(LOW_CYC - 1)) sck_q <= 1'b1;
          end
        end
        ST_LOAD: begin
          if (div_q == CW'(DIV)) begin
            ldac_q  <= 1'b1;
            state_q <= ST_IDLE;
            div_q   <= '0;
          end else begin
            if (div_q == '0) ldac_q <= 1'b0;  // one cycle after cs release
            div_q <= div_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cs_no   = cs_q;
  assign sck_o   = sck_q;
  assign sdi_o   = sh_q[DW-1];
  assign ldac_no = ldac_q;
  assign busy_o  = (state_q != ST_IDLE);

  assert_sck_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |-> !sck_q);
  assert_sdi_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_q && $past(sck_q)) |-> $stable(sdi_o));
  assert_ldac_after_cs_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ldac_q |-> cs_q);
  assert_busy_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $rose(ldac_q));
  assert_no_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && !cs_q && start_i) |=> !cs_q);
endmodule

// File: rtl/dacw_top.sv
module dacw_top #(
  parameter int                    N_CH    = 2,
  parameter int                    ADDR_W  = 8,
  parameter int                    DW      = 16,
  parameter int                    DIV     = 4,
  parameter logic [N_CH*ADDR_W-1:0] CH_ADDR = {8'h11, 8'h10}
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     data_i,
  input  logic              wr_i,
  output logic [N_CH-1:0]   cs_no,
  output logic [N_CH-1:0]   sck_o,
  output logic [N_CH-1:0]   sdi_o,
  output logic [N_CH-1:0]   ldac_no,
  output logic [N_CH-1:0]   busy_o
);
  logic [N_CH-1:0]    start;
  logic [N_CH*DW-1:0] word;

  dacw_decode #(
    .N_CH(N_CH), .ADDR_W(ADDR_W), .DW(DW), .CH_ADDR(CH_ADDR)
  ) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .data_i(data_i),
    .wr_i(wr_i), .start_o(start), .data_o(word)
  );

  for (genvar k = 0; k < N_CH; k++) begin : g_ser
    dacw_serializer #(.DW(DW), .DIV(DIV)) u_ser (
      .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start[k]),
      .data_i(word[k*DW +: DW]), .cs_no(cs_no[k]), .sck_o(sck_o[k]),
      .sdi_o(sdi_o[k]), .ldac_no(ldac_no[k]), .busy_o(busy_o[k])
    );
  end
endmodule

// File: tb/sim_dacw_top.sv
module sim_dacw_top;
  localparam int CLK_PERIOD = 10;
  localparam int DIV = 4;
  localparam int HI_CYC = DIV - DIV / 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  addr = '0;
  logic [15:0] data = '0;
  logic        wr = 1'b0;
  logic [1:0]  cs_n, sck, sdi, ldac_n, busy;

  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  dacw_top #(.DIV(DIV)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .data_i(data), .wr_i(wr),
    .cs_no(cs_n), .sck_o(sck), .sdi_o(sdi), .ldac_no(ldac_n), .busy_o(busy)
  );

  // frame monitor rebuilt purely from the serial lines
  int        frames [2] = '{0, 0};
  logic [15:0] rx   [2] = '{16'h0, 16'h0};
  logic [15:0] last_word [2] = '{16'h0, 16'h0};
  int        bits   [2] = '{0, 0};
  int        last_bits [2] = '{0, 0};
  int        hicnt  [2] = '{0, 0};
  int        lowcnt [2] = '{0, 0};
  int        last_ldac [2] = '{0, 0};
  int        since_cs [2] = '{99, 99};
  logic      psck [2] = '{1'b0, 1'b0};
  logic      pcs  [2] = '{1'b1, 1'b1};
  logic      pldac[2] = '{1'b1, 1'b1};
  logic      psdi [2] = '{1'b0, 1'b0};
  int v_r4 = 0, v_r5 = 0, v_r7 = 0, v_r8 = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      for (int c = 0; c < 2; c++) begin
        if (sck[c] && !psck[c]) begin
          rx[c] = {rx[c][14:0], sdi[c]};
          bits[c]++;
          if (cs_n[c]) v_r5++;
        end
        if (sck[c] && psck[c] && sdi[c] != psdi[c]) v_r4++;
        if (sck[c]) hicnt[c]++;
        if (!sck[c] && psck[c]) begin
          if (hicnt[c] != HI_CYC) v_r5++;
          hicnt[c] = 0;
        end
        if (!cs_n[c] && pcs[c]) bits[c] = 0;
        since_cs[c]++;
        if (cs_n[c] && !pcs[c]) begin
          frames[c]++;
          last_word[c] = rx[c];
          last_bits[c] = bits[c];
          since_cs[c] = 0;
        end
        if (!ldac_n[c]) begin
          lowcnt[c]++;
          if (!cs_n[c]) v_r7++;
        end
        if (!ldac_n[c] && pldac[c] && since_cs[c] != 1) v_r7++;
        if (ldac_n[c] && !pldac[c]) begin
          last_ldac[c] = lowcnt[c];
          lowcnt[c] = 0;
          if (busy[c]) v_r8++;
        end
        if ((!cs_n[c] || !ldac_n[c]) && !busy[c]) v_r8++;
        psck[c] = sck[c]; pcs[c] = cs_n[c]; pldac[c] = ldac_n[c]; psdi[c] = sdi[c];
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic put_write(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; data = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic wait_idle();
    int guard = 0;
    repeat (3) @(negedge clk);
    while (busy != 2'b00 && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  // {addr, data, target}: target 0/1 = channel, 2 = none
  localparam int NV = 7;
  localparam logic [25:0] VEC [NV] = '{
    {8'h10, 16'hA5C3, 2'd0},
    {8'h11, 16'h8001, 2'd1},
    {8'h12, 16'hFFFF, 2'd2},
    {8'h10, 16'h0000, 2'd0},
    {8'h11, 16'hFFFF, 2'd1},
    {8'h0F, 16'h1234, 2'd2},
    {8'h10, 16'h7FFE, 2'd0}
  };

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog act=%0h exp=%0h", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int f0, f1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check(cs_n == 2'b11 && ldac_n == 2'b11, "R11 lines", {cs_n, ldac_n}, 4'hF);
    check(sck == 2'b00 && busy == 2'b00, "R11 sck/busy", {sck, busy}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk: R1 R2 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [7:0] a; logic [15:0] d; logic [1:0] t;
      {a, d, t} = VEC[i];
      f0 = frames[0]; f1 = frames[1];
      put_write(a, d);
      wait_idle();
      check(frames[0] == f0 + (t == 2'd0 ? 1 : 0), "R1/R2 ch0 frames", frames[0], f0);
      check(frames[1] == f1 + (t == 2'd1 ? 1 : 0), "R1/R2 ch1 frames", frames[1], f1);
      if (t != 2'd2) begin
        check(last_word[t] == d, "R4 word", last_word[t], d);
        check(last_bits[t] == 16, "R6 bit count", last_bits[t], 16);
        check(last_ldac[t] == DIV, "R7 ldac length", last_ldac[t], DIV);
      end
    end

    // R2: matching address without write strobe
    f0 = frames[0]; f1 = frames[1];
    @(negedge clk); addr = 8'h10; data = 16'hBEEF;
    repeat (10) @(negedge clk);
    addr = 8'h11;
    repeat (10) @(negedge clk);
    check(frames[0] == f0 && frames[1] == f1 && busy == 0, "R2 no strobe",
          frames[0] + frames[1], f0 + f1);

    // R3 busy latency
    @(negedge clk); addr = 8'h11; data = 16'h3C5A; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
    check(busy[1] == 1'b0, "R3 busy after edge 1", busy[1], 0);
    @(negedge clk);
    check(busy[1] == 1'b1, "R3 busy after edge 2", busy[1], 1);
    wait_idle();
    check(last_word[1] == 16'h3C5A, "R4 word ch1", last_word[1], 16'h3C5A);

    // R9 retrigger while busy is dropped
    f0 = frames[0];
    put_write(8'h10, 16'hC0DE);
    repeat (10) @(negedge clk);
    put_write(8'h10, 16'h1111);
    wait_idle();
    check(frames[0] == f0 + 1, "R9 single frame", frames[0], f0 + 1);
    check(last_word[0] == 16'hC0DE, "R9 word kept", last_word[0], 16'hC0DE);

    // R10 back-to-back writes to both channels
    f0 = frames[0]; f1 = frames[1];
    @(negedge clk); addr = 8'h10; data = 16'h9669; wr = 1'b1;
    @(negedge clk); addr = 8'h11; data = 16'h0FF0;
    @(negedge clk); wr = 1'b0;
    wait_idle();
    check(frames[0] == f0 + 1 && frames[1] == f1 + 1, "R10 both frames",
          {frames[0][15:0], frames[1][15:0]}, {f0[15:0] + 16'd1, f1[15:0] + 16'd1});
    check(last_word[0] == 16'h9669, "R10 ch0 word", last_word[0], 16'h9669);
    check(last_word[1] == 16'h0FF0, "R10 ch1 word", last_word[1], 16'h0FF0);

    // R10 channel 1 write during channel 0 load strobe
    put_write(8'h10, 16'h5555);
    while (ldac_n[0]) @(negedge clk);
    put_write(8'h11, 16'hAAAA);
    wait_idle();
    check(last_word[0] == 16'h5555, "R10 ch0 during strobe", last_word[0], 16'h5555);
    check(last_word[1] == 16'hAAAA, "R10 ch1 during strobe", last_word[1], 16'hAAAA);

    // monitor violations
    check(v_r4 == 0, "R4 sdi stable in high phase", v_r4, 0);
    check(v_r5 == 0, "R5 sck shape", v_r5, 0);
    check(v_r7 == 0, "R7 ldac timing", v_r7, 0);
    check(v_r8 == 0, "R8 busy span", v_r8, 0);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule